// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Slave

This block is a two-wire serial bus slave that gives an external master byte access to a 128-entry, 8-bit internal store. It samples the clock and data lines with a faster system clock through two-flop synchronizers. It pulls the data line low only through an open-drain enable, so the line is never driven high. A 7-bit identification code on an input port chooses which bus address the slave answers to.

A write transfer carries the identification byte with the direction bit clear, then one address byte, then any number of data bytes. Data bytes fill consecutive locations until the end of the 16-byte page that holds the starting address. Bytes past that page end are acknowledged and dropped, so a write never wraps back to the start of its page. A read sets the pointer the same way, then uses a repeated START and the identification byte with the direction bit set. The slave then streams bytes while the master acknowledges them. The read pointer is not limited to a page, and locations above the store return all ones. The bus pins carry the only data flow, so the block has no valid/ready port. The master paces every transfer with the clock line, and the slave never holds the clock low.

Top module: `tws_page_slave`

## Requirements
- R1: After reset, and after any STOP, the slave is idle: `sda_oe_o` is 0 and nothing happens until a START is seen. START is a falling data line while the clock line is high. STOP is a rising data line while the clock line is high.
- R2: A byte whose upper 7 bits equal `dev_id_i` is acknowledged (data pulled low on the ninth clock). Bit 0 of that byte is the direction: 0 means write and 1 means read. The address byte and every data byte of a write are also acknowledged.
- R3: If the identification byte does not match, the slave gives no acknowledge. It then ignores all later bytes until the next START, and no location is written.
- R4: In a write, the first data byte is stored at the location given by the low 7 bits of the address byte. Each later byte goes to the next location.
- R5: Pages are 16 bytes, and the page is address bits 6:4. A write byte that would land past the end of the starting page is acknowledged but not stored, so the page never wraps.
- R6: A random read is made of the write identification byte, the address byte, a repeated START and the read identification byte. It returns the byte at that address, most significant bit first.
- R7: The slave keeps sending bytes while the master acknowledges on the ninth clock. The pointer rises by one for each byte sent and crosses page boundaries freely.
- R8: Any read from a location at or above 128 returns 0xFF.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and stays released until the next START or STOP.
- R10: A START or STOP in the middle of a byte abandons the transfer, and the partly received byte is not stored. A START begins a new transfer at once.
- R11: `sda_oe_o` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_id_i | input | 7 | Identification code the slave answers to |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume a well-formed bus. The clock line stays at each level for several system clocks, so that both synchronized edges are seen. The master changes the data line only while the clock is low, except when it makes START and STOP. Under those conditions the slave's own enable can only change in the low phase. The bench master builds every bus event from quarter-bit waits of ten system clocks. It makes aborts only by issuing a START or STOP pattern between bits. Random transfers are kept within a legal address range and a bounded length.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tws_state_e;

  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tws_bus_events.sv
module tws_bus_events #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] syn;
  logic             scl_p_q, sda_p_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    tws_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw[g]),
      .q_o  (syn[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= syn[0];
      sda_p_q <= syn[1];
    end
  end

  assign sda_lvl_o  = syn[1];
  assign scl_rise_o = syn[0] & ~scl_p_q;
  assign scl_fall_o = ~syn[0] & scl_p_q;
  assign start_o    = syn[0] & scl_p_q & sda_p_q & ~syn[1];
  assign stop_o     = syn[0] & scl_p_q & ~sda_p_q & syn[1];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i >= PTR_W'(DEPTH)) ? '1 : mem_q[raddr_i[ADDR_W-1:0]];
endmodule

// File: rtl/tws_page_slave.sv
module tws_page_slave
  import tws_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_id_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned PG_W  = ADDR_W - PAGE_W;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(1 << ADDR_W);

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  tws_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  tws_state_e             state_q;
  logic [3:0]             bitcnt_q;
  logic [BYTE_BITS-1:0]   shreg_q, tx_q, rdata;
  logic [PTR_W-1:0]       ptr_q, ptr_inc;
  logic [PG_W-1:0]        page_q;
  logic                   rw_q, mack_q, oe_q;
  logic                   byte_done, in_page, id_hit, mem_we;

  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign in_page   = (ptr_q[PTR_W-1:PAGE_W] == {1'b0, page_q});
  assign ptr_inc   = (ptr_q == PTR_END) ? ptr_q : ptr_q + 1'b1;
  assign id_hit    = (shreg_q[7:1] == dev_id_i);
  assign mem_we    = (state_q == ST_WDATA) && byte_done && in_page;

  tws_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_BITS), .PTR_W(PTR_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (mem_we),
    .waddr_i(ptr_q[ADDR_W-1:0]),
    .wdata_i(shreg_q),
    .raddr_i(ptr_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      page_q   <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_ev) begin
      state_q  <= ST_ID;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_ev) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ID, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[BYTE_BITS-2:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
          end
          if (byte_done) begin
            bitcnt_q <= '0;
            if (state_q == ST_ID) begin
              if (id_hit) begin
                rw_q    <= shreg_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ID_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end else if (state_q == ST_ADDR) begin
              ptr_q   <= {1'b0, shreg_q[ADDR_W-1:0]};
              page_q  <= shreg_q[ADDR_W-1:PAGE_W];
              oe_q    <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              ptr_q   <= ptr_inc;
              oe_q    <= 1'b1;
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_ID_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rdata;
              oe_q    <= ~rdata[BYTE_BITS-1];
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) bitcnt_q <= bitcnt_q + 4'd1;
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              bitcnt_q <= '0;
              oe_q     <= 1'b0;
              ptr_q    <= ptr_inc;
              state_q  <= ST_RACK;
            end else begin
              tx_q <= {tx_q[BYTE_BITS-2:0], 1'b0};
              oe_q <= ~tx_q[BYTE_BITS-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rdata;
              oe_q    <= ~rdata[BYTE_BITS-1];
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

module tws_page_slave_chk
  import tws_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input tws_state_e       state,
  input logic [PTR_W-1:0] ptr
);
  logic scl_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scl_hi_q <= 1'b1;
    else if (scl_rise) scl_hi_q <= 1'b1;
    else if (scl_fall) scl_hi_q <= 1'b0;
  end

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_hi_q);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_oe);

  // R9
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(1 << (PTR_W - 1)));
endmodule

bind tws_page_slave tws_page_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sda_oe  (sda_oe_o),
  .scl_rise(scl_rise),
  .scl_fall(scl_fall),
  .start_ev(start_ev),
  .stop_ev (stop_ev),
  .state   (state_q),
  .ptr     (ptr_q)
);

// File: tb/tws_page_slave_tb_top.sv
module tws_page_slave_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_oe = 1'b0;
  logic [6:0] dev_id = 7'h52;
  logic       sda_oe;
  wire        sda_bus = ~(m_oe | sda_oe);

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];
  logic [7:0] wbuf [32];

  always #10 clk = ~clk;

  tws_page_slave dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_id_i(dev_id),
    .scl_i   (m_scl),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] exp_rd(input int a);
    return (a >= 128) ? 8'hFF : model[a];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_oe = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_oe = 1'b1; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_oe = 1'b0; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_oe = ~b[7-i]; qwait();
      m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_oe = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    ack = ~sda_bus; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    m_oe = 1'b0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      qwait();
      m_scl = 1'b1; qwait();
      d = {d[6:0], sda_bus}; qwait();
      m_scl = 1'b0; qwait();
    end
    m_oe = mack; qwait();
    m_scl = 1'b1; qwait(); qwait();
    m_scl = 1'b0; qwait();
    m_oe = 1'b0;
  endtask

  // Write n bytes from wbuf starting at addr; model applies R4/R5.
  task automatic wr_txn(input int addr, input int n);
    logic ack;
    int p;
    bus_start();
    send_byte({dev_id, 1'b0}, ack); check("R2 id ack", ack, 1);
    send_byte(8'(addr), ack);       check("R2 addr ack", ack, 1);
    p = addr;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check("R5 data ack", ack, 1);
      if (p < 128 && (p >> 4) == (addr >> 4)) model[p] = wbuf[i];
      p++;
    end
    bus_stop();
    check("R1 idle after stop", sda_oe, 0);
  endtask

  task automatic rd_txn(input int addr, input int n, input string req, input bit probe);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({dev_id, 1'b0}, ack); check("R2 id ack", ack, 1);
    send_byte(8'(addr), ack);       check("R2 addr ack", ack, 1);
    bus_start();
    send_byte({dev_id, 1'b1}, ack); check("R6 read id ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check(req, d, exp_rd(addr + i));
    end
    if (probe) begin
      for (int i = 0; i < 9; i++) begin
        qwait(); m_scl = 1'b1; qwait();
        check("R9 released after nack", sda_bus, 1);
        qwait(); m_scl = 1'b0; qwait();
      end
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    int a, n;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    qwait();
    check("R1 reset released", sda_oe, 0);

    // R3: wrong identification, later bytes ignored
    bus_start();
    send_byte({dev_id ^ 7'h01, 1'b0}, ack); check("R3 id nack", ack, 0);
    send_byte(8'h10, ack);                  check("R3 ignored addr", ack, 0);
    send_byte(8'hAA, ack);                  check("R3 ignored data", ack, 0);
    bus_stop();
    rd_txn(16, 1, "R3 no write", 0);

    // R4 / R6: single write and random read
    wbuf[0] = 8'h3C;
    wr_txn(5, 1);
    rd_txn(5, 1, "R6 random read", 0);

    // R5: page write past page end, then R7 sequential read across pages
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr_txn(28, 8);
    rd_txn(28, 8, "R7 sequential read R5 no wrap", 0);
    rd_txn(16, 4, "R5 page start untouched", 0);

    // R8 / R9: read past the top, then check release after nack
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(126, 2);
    rd_txn(126, 5, "R8 top read", 1);

    // R10: STOP in mid-byte
    bus_start();
    send_byte({dev_id, 1'b0}, ack); check("R2 id ack", ack, 1);
    send_byte(8'h30, ack);          check("R2 addr ack", ack, 1);
    send_bits(8'h99, 4);
    bus_stop();
    rd_txn(48, 1, "R10 stop abort", 0);

    // R10: START in mid-byte starts a fresh write
    bus_start();
    send_byte({dev_id, 1'b0}, ack); check("R2 id ack", ack, 1);
    send_byte(8'h31, ack);          check("R2 addr ack", ack, 1);
    send_bits(8'h77, 3);
    wbuf[0] = 8'h5A;
    wr_txn(50, 1);
    rd_txn(49, 2, "R10 start abort", 0);

    // Random mix of writes and reads
    for (int t = 0; t < 14; t++) begin
      a = int'($urandom_range(127, 0));
      if ($urandom_range(1, 0) == 1) begin
        n = int'($urandom_range(12, 1));
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_txn(a, n);
      end else begin
        n = int'($urandom_range(8, 1));
        rd_txn(a, n, "R7 random read", 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule